// File: doc/BRIEF.md
# Aperture-Based Address Remapper

This block translates request addresses for several bus masters before they reach an interconnect. Each master sees a 4 GB space cut into sixteen 256 MB windows. The top nibble of a request address picks a window. That window's entry gives two things: the index of the target slave, and a new top nibble that replaces the original one. The lower 28 bits pass through unchanged. A slave index of zero marks the window as unmapped, and a request that lands there comes back with a decode-error flag and no slave selected.

Each master has its own map. Software loads the maps into shadow registers through a small word-wide register port, and they have no effect on traffic while they sit there. A write to a shared commit register copies a master's shadow map into its live map, with one commit bit per master. The copy never happens while that master is presenting a request, so no single request is ever translated with part of an old map and part of a new one.

Top module: `aper_remap`

## Requirements
- R1: A request on master m (`req_valid[m]` high at a clock edge) produces `rsp_valid[m]` high one clock later. `rsp_addr` holds the window's replacement nibble in bits [31:28], and request bits [27:0] unchanged. `rsp_valid[m]` is low in every cycle that follows a cycle with no request.
- R2: For a mapped window, `rsp_slave` equals the live 4-bit slave index of the window picked by request bits [31:28], and `rsp_decerr` is 0.
- R3: A window whose live slave index is 0 is unmapped. A request to it returns `rsp_decerr` = 1 and `rsp_slave` = 0.
- R4: Master m's map block is at byte offset 16*m. Windows 0-7 use the slave-index word at +0x0 and the replacement-nibble word at +0x8. Windows 8-15 use the slave-index word at +0x4 and the replacement-nibble word at +0xC. Window w takes nibble [4(w mod 8)+3 : 4(w mod 8)] of its word.
- R5: Writing a map block changes only the shadow copy. Translation keeps using the live map until a commit.
- R6: A write to the commit register at offset 0x100 copies the shadow map of every master m whose data bit m is 1 into its live map. Masters whose bit is 0 keep their live map.
- R7: If `req_valid[m]` is high when a commit for m arrives, the copy waits. It happens at the first clock edge where `req_valid[m]` is low, and every request before then is translated with the old map.
- R8: After reset, all shadow and live maps are zero (every window unmapped), and no response is valid.
- R9: With `cfg_we` low, `cfg_rdata` returns the shadow word at `cfg_addr`, and 0 for any other offset. Writes to offsets outside the map blocks and the commit register change nothing.
- R10: The masters are independent. A request, write or commit for one master never alters another master's translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | CFG_AW | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Shadow register read data |
| req_valid | input | NUM_MST | Per-master request valid |
| req_addr | input | NUM_MST*32 | Per-master request address, master m in [32m+31:32m] |
| rsp_valid | output | NUM_MST | Per-master translated request valid |
| rsp_slave | output | NUM_MST*4 | Per-master selected slave index |
| rsp_addr | output | NUM_MST*32 | Per-master translated address |
| rsp_decerr | output | NUM_MST | Per-master decode error (unmapped window) |

## Verification
The assertions assume that register offsets are word aligned, and that each master's request is a single beat: a master that keeps `req_valid` high is treated as one unbroken busy period. The deferral property relies on that, because it allows the live map to change only on edges where the master's request is low. The bench drives only aligned offsets and changes inputs on the falling clock edge. In the deferral scenario it holds a request high across the commit on purpose, then drops it for one cycle so the waiting copy can land.

// File: rtl/aper_pkg.sv
// Shared constants and helpers for the aperture remapper.
// Assumes a 32-bit address split into 16 windows selected by bits [31:28].
package aper_pkg;
    localparam int ADDR_W   = 32;
    localparam int NIB_W    = 4;
    localparam int NUM_APER = 16;
    localparam int MAP_W    = NUM_APER * NIB_W;
    localparam int LOW_W    = ADDR_W - NIB_W;

    typedef logic [MAP_W-1:0] map_vec_t;
    typedef logic [NIB_W-1:0] nib_t;

    // Extract the nibble belonging to window idx from a packed map.
    function automatic nib_t pick_nib(map_vec_t v, nib_t idx);
        return v[idx*NIB_W +: NIB_W];
    endfunction
endpackage

// File: rtl/aper_cfg_regs.sv
// Shadow map registers and commit strobe decode.
// Assumes word-aligned offsets, NUM_MST <= 32 and 16*NUM_MST <= UPD_OFS.
module aper_cfg_regs
    import aper_pkg::*;
#(
    parameter int NUM_MST = 4,
    parameter int CFG_AW  = 12,
    parameter int UPD_OFS = 'h100
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [CFG_AW-1:0]          cfg_addr,
    input  logic [31:0]                cfg_wdata,
    output logic [31:0]                cfg_rdata,
    output logic [NUM_MST*MAP_W-1:0]   shd_sel,
    output logic [NUM_MST*MAP_W-1:0]   shd_off,
    output logic [NUM_MST-1:0]         upd_strobe
);
    localparam int BLK_W = CFG_AW - 4;
    localparam logic [CFG_AW:0] SPAN = (CFG_AW+1)'(NUM_MST * 16);

    logic             hit_blk;
    logic [BLK_W-1:0] blk_idx;
    logic [1:0]       word_sel;

    // Decode which block and which word an offset addresses.
    always_comb begin
        hit_blk  = ({1'b0, cfg_addr} < SPAN) && (cfg_addr[1:0] == 2'b00);
        blk_idx  = cfg_addr[CFG_AW-1:4];
        word_sel = cfg_addr[3:2];
    end

    // Commit strobe: one bit per master, valid only in the write cycle.
    always_comb begin
        upd_strobe = '0;
        if (cfg_we && cfg_addr == CFG_AW'(UPD_OFS))
            upd_strobe = cfg_wdata[NUM_MST-1:0];
    end

    for (genvar m = 0; m < NUM_MST; m++) begin : g_shd
        logic wr_here;
        assign wr_here = cfg_we && hit_blk && (blk_idx == BLK_W'(m));

        // Load the addressed shadow word of master m.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shd_sel[m*MAP_W +: MAP_W] <= '0;
                shd_off[m*MAP_W +: MAP_W] <= '0;
            end else if (wr_here) begin
                case (word_sel)
                    2'd0: shd_sel[m*MAP_W      +: 32] <= cfg_wdata;
                    2'd1: shd_sel[m*MAP_W + 32 +: 32] <= cfg_wdata;
                    2'd2: shd_off[m*MAP_W      +: 32] <= cfg_wdata;
                    default: shd_off[m*MAP_W + 32 +: 32] <= cfg_wdata;
                endcase
            end
        end
    end

    // Read back the addressed shadow word, zero elsewhere.
    always_comb begin
        cfg_rdata = '0;
        for (int m = 0; m < NUM_MST; m++) begin
            if (hit_blk && blk_idx == BLK_W'(m)) begin
                case (word_sel)
                    2'd0: cfg_rdata = shd_sel[m*MAP_W      +: 32];
                    2'd1: cfg_rdata = shd_sel[m*MAP_W + 32 +: 32];
                    2'd2: cfg_rdata = shd_off[m*MAP_W      +: 32];
                    default: cfg_rdata = shd_off[m*MAP_W + 32 +: 32];
                endcase
            end
        end
    end
endmodule

// File: rtl/aper_commit.sv
// Live map of one master. Copies the shadow map on a commit, deferring
// the copy while the master presents a request.
// Assumes a request is single-beat, so a low req_busy is a safe point.
module aper_commit
    import aper_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     upd,
    input  logic     req_busy,
    input  map_vec_t shd_sel,
    input  map_vec_t shd_off,
    output map_vec_t act_sel,
    output map_vec_t act_off
);
    logic pend;

    // Hold a requested commit and apply it when the master is idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend    <= 1'b0;
            act_sel <= '0;
            act_off <= '0;
        end else if ((upd || pend) && !req_busy) begin
            pend    <= 1'b0;
            act_sel <= shd_sel;
            act_off <= shd_off;
        end else if (upd) begin
            pend    <= 1'b1;
        end
    end
endmodule

// File: rtl/aper_xlate.sv
// Registered address translation for one master using its live map.
// Assumes the live map does not change on an edge with a request.
module aper_xlate
    import aper_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  map_vec_t          act_sel,
    input  map_vec_t          act_off,
    output logic              rsp_valid,
    output nib_t              rsp_slave,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              rsp_decerr
);
    nib_t win, slv, nib;

    // Look up the window entry for the incoming address.
    always_comb begin
        win = req_addr[ADDR_W-1 -: NIB_W];
        slv = pick_nib(act_sel, win);
        nib = pick_nib(act_off, win);
    end

    // Register the translated request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_slave  <= '0;
            rsp_addr   <= '0;
            rsp_decerr <= 1'b0;
        end else begin
            rsp_valid  <= req_valid;
            rsp_slave  <= slv;
            rsp_addr   <= {nib, req_addr[LOW_W-1:0]};
            rsp_decerr <= req_valid && (slv == '0);
        end
    end
endmodule

// File: rtl/aper_remap.sv
// Multi-master aperture remapper: shadow registers, per-master commit
// and per-master translation.
// Assumes word-aligned register offsets and single-beat requests.
module aper_remap
    import aper_pkg::*;
#(
    parameter int NUM_MST = 4,
    parameter int CFG_AW  = 12,
    parameter int UPD_OFS = 'h100
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [CFG_AW-1:0]       cfg_addr,
    input  logic [31:0]             cfg_wdata,
    output logic [31:0]             cfg_rdata,
    input  logic [NUM_MST-1:0]      req_valid,
    input  logic [NUM_MST*32-1:0]   req_addr,
    output logic [NUM_MST-1:0]      rsp_valid,
    output logic [NUM_MST*4-1:0]    rsp_slave,
    output logic [NUM_MST*32-1:0]   rsp_addr,
    output logic [NUM_MST-1:0]      rsp_decerr
);
    logic [NUM_MST*MAP_W-1:0] shd_sel, shd_off;
    logic [NUM_MST*MAP_W-1:0] act_sel, act_off;
    logic [NUM_MST-1:0]       upd_strobe;

    aper_cfg_regs #(.NUM_MST(NUM_MST), .CFG_AW(CFG_AW), .UPD_OFS(UPD_OFS)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .shd_sel    (shd_sel),
        .shd_off    (shd_off),
        .upd_strobe (upd_strobe)
    );

    for (genvar m = 0; m < NUM_MST; m++) begin : g_mst
        aper_commit u_commit (
            .clk      (clk),
            .rst_n    (rst_n),
            .upd      (upd_strobe[m]),
            .req_busy (req_valid[m]),
            .shd_sel  (shd_sel[m*MAP_W +: MAP_W]),
            .shd_off  (shd_off[m*MAP_W +: MAP_W]),
            .act_sel  (act_sel[m*MAP_W +: MAP_W]),
            .act_off  (act_off[m*MAP_W +: MAP_W])
        );

        aper_xlate u_xlate (
            .clk        (clk),
            .rst_n      (rst_n),
            .req_valid  (req_valid[m]),
            .req_addr   (req_addr[m*32 +: 32]),
            .act_sel    (act_sel[m*MAP_W +: MAP_W]),
            .act_off    (act_off[m*MAP_W +: MAP_W]),
            .rsp_valid  (rsp_valid[m]),
            .rsp_slave  (rsp_slave[m*4 +: 4]),
            .rsp_addr   (rsp_addr[m*32 +: 32]),
            .rsp_decerr (rsp_decerr[m])
        );
    end
endmodule

// File: rtl/aper_remap_chk.sv
// Property checker for aper_remap, attached by bind below.
// Assumes single-beat requests and synchronous active-low reset.
module aper_remap_chk #(
    parameter int NUM_MST = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NUM_MST-1:0]      req_valid,
    input logic [NUM_MST*32-1:0]   req_addr,
    input logic [NUM_MST-1:0]      rsp_valid,
    input logic [NUM_MST*4-1:0]    rsp_slave,
    input logic [NUM_MST*32-1:0]   rsp_addr,
    input logic [NUM_MST-1:0]      rsp_decerr,
    input logic [NUM_MST*64-1:0]   act_sel
);
    for (genvar m = 0; m < NUM_MST; m++) begin : g_chk
        AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n) req_valid[m] |=> rsp_valid[m]); // R1
        AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n) !req_valid[m] |=> !rsp_valid[m]); // R1
        AST_LOW_BITS_PASS: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid[m] |-> rsp_addr[m*32 +: 28] == $past(req_addr[m*32 +: 28])); // R1
        AST_MAPPED_HAS_SLAVE: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid[m] && !rsp_decerr[m]) |-> rsp_slave[m*4 +: 4] != 4'd0); // R2
        AST_DECERR_NO_SLAVE: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid[m] && rsp_decerr[m]) |-> rsp_slave[m*4 +: 4] == 4'd0); // R3
        AST_MAP_HELD_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n) req_valid[m] |=> $stable(act_sel[m*64 +: 64])); // R7
    end
endmodule

bind aper_remap aper_remap_chk #(.NUM_MST(NUM_MST)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .rsp_valid  (rsp_valid),
    .rsp_slave  (rsp_slave),
    .rsp_addr   (rsp_addr),
    .rsp_decerr (rsp_decerr),
    .act_sel    (act_sel)
);

// File: tb/sim_aper_remap.sv
module sim_aper_remap;
    localparam int NM = 4;
    localparam int AW = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [AW-1:0]     cfg_addr = '0;
    logic [31:0]       cfg_wdata = '0;
    logic [31:0]       cfg_rdata;
    logic [NM-1:0]     req_valid = '0;
    logic [NM*32-1:0]  req_addr = '0;
    logic [NM-1:0]     rsp_valid;
    logic [NM*4-1:0]   rsp_slave;
    logic [NM*32-1:0]  rsp_addr;
    logic [NM-1:0]     rsp_decerr;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    // Bench model: [m][0]=sel lo, [1]=sel hi, [2]=off lo, [3]=off hi
    logic [31:0] sh [NM][4];
    logic [31:0] ac [NM][4];

    always #10 clk = ~clk;

    aper_remap #(.NUM_MST(NM), .CFG_AW(AW), .UPD_OFS('h100)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_slave(rsp_slave),
        .rsp_addr(rsp_addr), .rsp_decerr(rsp_decerr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] m_nib(input int m, input int base, input logic [3:0] w);
        logic [31:0] word;
        word = (w < 8) ? ac[m][base] : ac[m][base+1];
        return word[(w % 8)*4 +: 4];
    endfunction

    task automatic cfg_wr(input int ofs, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = AW'(ofs); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic shadow_wr(input int m, input int word, input logic [31:0] d);
        cfg_wr(m*16 + word*4, d);
        sh[m][word] = d;
    endtask

    // Commit with all targeted masters idle.
    task automatic commit(input logic [NM-1:0] mask);
        cfg_wr('h100, 32'(mask));
        for (int m = 0; m < NM; m++)
            if (mask[m]) for (int k = 0; k < 4; k++) ac[m][k] = sh[m][k];
    endtask

    task automatic rd_chk(input string tag, input int ofs, input logic [31:0] exp);
        @(negedge clk);
        cfg_addr = AW'(ofs);
        #1;
        check(tag, cfg_rdata, exp);
    endtask

    // Single request on master m; response sampled at the following negedge.
    task automatic xl(input string tag, input int m, input logic [31:0] a);
        logic [3:0] s, o;
        s = m_nib(m, 0, a[31:28]);
        o = m_nib(m, 2, a[31:28]);
        @(negedge clk);
        req_valid[m] = 1'b1; req_addr[m*32 +: 32] = a;
        @(negedge clk);
        req_valid[m] = 1'b0;
        check({tag, " R1 valid"}, 32'(rsp_valid[m]), 32'd1);
        check({tag, " R1 addr"}, rsp_addr[m*32 +: 32], {o, a[27:0]});
        check({tag, " R2 slave"}, 32'(rsp_slave[m*4 +: 4]), 32'(s));
        check({tag, " R3 decerr"}, 32'(rsp_decerr[m]), 32'(s == 4'd0));
    endtask

    task automatic t_reset;
        check("R8 no rsp after reset", 32'(rsp_valid), 32'd0);
        rd_chk("R8 shadow zero", 'h04, 32'd0);
        xl("R8 unmapped at reset", 0, 32'h8123_4567);
        check("R3 reset decerr", 32'(rsp_decerr[0]), 32'd1);
        @(negedge clk);
        check("R1 valid drops", 32'(rsp_valid[0]), 32'd0);
    endtask

    task automatic t_lower;
        shadow_wr(0, 0, 32'h0000_0321);   // windows 0..2 mapped
        shadow_wr(0, 2, 32'h0000_0A5F);
        rd_chk("R9 readback sel0", 'h00, 32'h0000_0321);
        rd_chk("R4 readback off0", 'h08, 32'h0000_0A5F);
        commit(4'b0001);
        xl("R4 win0", 0, 32'h0ABC_DEF0);
        xl("R4 win1", 0, 32'h1000_0004);
        xl("R4 win2", 0, 32'h2FFF_FFFC);
        xl("R3 win3 unmapped", 0, 32'h3000_0000);
    endtask

    task automatic t_upper;
        shadow_wr(0, 1, 32'h7000_0009);   // windows 8 and 15
        shadow_wr(0, 3, 32'hE000_000C);
        commit(4'b0001);
        xl("R4 win8", 0, 32'h8765_4321);
        xl("R4 win15", 0, 32'hF000_1000);
        xl("R3 win12 unmapped", 0, 32'hC000_0000);
    endtask

    task automatic t_shadow;
        shadow_wr(0, 0, 32'h0000_0004);
        rd_chk("R9 new shadow visible", 'h00, 32'h0000_0004);
        xl("R5 old map before commit", 0, 32'h1000_0000);
        check("R5 slave still old", 32'(rsp_slave[3:0]), 32'd2);
        commit(4'b0001);
        xl("R5 new map after commit", 0, 32'h1000_0000);
    endtask

    task automatic t_isolate;
        shadow_wr(1, 0, 32'h0000_0006);
        shadow_wr(1, 2, 32'h0000_0003);
        shadow_wr(0, 0, 32'h0000_00FF);
        commit(4'b0010);
        xl("R6 master1 committed", 1, 32'h0111_2222);
        xl("R10 master0 untouched", 0, 32'h1000_0000);
        check("R10 m0 win1 still unmapped", 32'(rsp_decerr[0]), 32'd1);
        xl("R10 master2 still empty", 2, 32'h0000_0000);
        commit(4'b0001);
        xl("R6 master0 later commit", 0, 32'h1000_0000);
    endtask

    task automatic t_defer;
        logic [3:0] old_s;
        old_s = m_nib(1, 0, 4'h0);
        shadow_wr(1, 0, 32'h0000_000B);
        @(negedge clk);
        req_valid[1] = 1'b1; req_addr[32 +: 32] = 32'h0000_0010;
        cfg_we = 1'b1; cfg_addr = AW'('h100); cfg_wdata = 32'h2;
        @(negedge clk);
        cfg_we = 1'b0;
        check("R7 held req uses old map", 32'(rsp_slave[7:4]), 32'(old_s));
        @(negedge clk);
        check("R7 still old while busy", 32'(rsp_slave[7:4]), 32'(old_s));
        req_valid[1] = 1'b0;
        for (int k = 0; k < 4; k++) ac[1][k] = sh[1][k];
        xl("R7 commit applied after idle", 1, 32'h0000_0010);
    endtask

    task automatic t_ignored;
        cfg_wr('h040, 32'hFFFF_FFFF);  // past last block
        cfg_wr('h104, 32'hFFFF_FFFF);  // beside commit register
        rd_chk("R9 outside block reads 0", 'h040, 32'd0);
        rd_chk("R9 master0 sel0 intact", 'h00, sh[0][0]);
        rd_chk("R9 master3 intact", 'h30, 32'd0);
        xl("R9 master3 still unmapped", 3, 32'h5000_0000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int m = 0; m < NM; m++)
            for (int k = 0; k < 4; k++) begin sh[m][k] = '0; ac[m][k] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_lower;
        t_upper;
        t_shadow;
        t_isolate;
        t_defer;
        t_ignored;
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule